// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a two-wire serial slave that gives an external bus master access to a small bank of byte-wide control registers. It watches the clock and data lines, which arrive already synchronized to the system clock. It recognizes its own 7-bit device address. It acknowledges bytes by pulling the data line low through an open-drain enable. The registers themselves sit outside the block. The slave presents a one-cycle write strobe with an offset and a data byte, and it takes read data back on a combinational return path, indexed by the same offset.

The byte after the address is a command byte. Its top bit picks one of two access modes. The single-byte mode carries a 5-bit register offset. The block mode always starts at offset zero. A block write sends a length byte before the data, and the slave accepts no more data bytes than that length announces. A block read, started with a repeated START and the read address, returns the bank size first and then the registers in ascending order. Every byte travels most significant bit first. A STOP or a START seen at any point abandons the current transfer.

Top module: `twi_reg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 69h (write byte D2h, read byte D3h), by holding its SDA enable high for the ninth clock of that byte. Any other address is not acknowledged, and the slave then ignores the bus until the next START or STOP, issuing no write strobe.
- R2: In the command byte, bit 7 = 1 selects single-byte access at the offset in bits 4:0, and bit 7 = 0 selects block access from offset 0. A command byte whose bits 6:5 are not 00 is not acknowledged, and no write follows it.
- R3: In single-byte mode each acknowledged data byte gives exactly one one-cycle write strobe, carrying the current offset and the byte. Further bytes in the same transfer go to the next offsets in turn.
- R4: In block-write mode the first byte after the command is a length N, which is acknowledged. The next N data bytes are written to offsets 0, 1, 2 and onward. Any data byte after those N is not acknowledged and is not written.
- R5: A write to an offset at or above 12 (the bank size) is not acknowledged and produces no write strobe.
- R6: A single-byte read (command, repeated START, then D3h) returns the register at the commanded offset, MSB first.
- R7: A block read returns the bank size (0Ch) as its first byte, then registers 0, 1, 2 and onward, for as long as the master acknowledges.
- R8: A read of an offset at or above 12 returns FFh.
- R9: After the master does not acknowledge a read byte, the slave releases SDA and keeps it released through any further clocks until a START or a STOP.
- R10: A STOP or a START in any state, including partway through a byte, releases SDA. After a START the slave receives a fresh address byte.
- R11: The SDA enable changes only after a falling edge of SCL, or at a START or STOP. It never changes while SCL stays high.
- R12: After reset the SDA enable and the write strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock line level |
| sda_i | input | 1 | Synchronized serial data line level |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 5 | Register offset for a write or a read |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr` |

## Verification
The hardest situations to reach from the pins are transfers that break off partway through. One is a START or STOP landing after only a few bits of a byte. Another is a block write that sends more bytes than its length announced. A third is a read that runs past the end of the bank. The master model in the bench generates bits one by one. It can cut a byte off after any bit count, add extra clocks after a NACK, and keep acknowledging past the last register. Before each such interruption it checks that the slave has let go of SDA and has issued no stray write, and afterwards it checks that a normal transfer still works.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;

   // Top-level bus phase of the slave
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,     // shifting in a byte from the master
      ST_ACK,    // ninth clock of a received byte
      ST_TX,     // shifting out a byte to the master
      ST_RACK,   // ninth clock of a transmitted byte (master answers)
      ST_WAIT    // ignoring the bus until START/STOP
   } twi_state_t;

   // Meaning of the byte currently being received
   typedef enum logic [1:0] {
      K_ADDR,
      K_CMD,
      K_CNT,
      K_DATA
   } twi_kind_t;

endpackage

// File: rtl/twi_line_events.sv
module twi_line_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   // the idle bus is high on both lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  =  scl_i & ~scl_q;
   assign scl_fall  = ~scl_i &  scl_q;
   assign start_det =  scl_i &  scl_q & ~sda_i &  sda_q;
   assign stop_det  =  scl_i &  scl_q &  sda_i & ~sda_q;

endmodule

// File: rtl/twi_byte_shift.sv
module twi_byte_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rx_bit,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_val,
   input  logic              tx_shift,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              tx_next_msb
);

   logic [BYTE_W-1:0] tx_q;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("twi_byte_shift: BYTE_W must be at least 2");
      end
   endgenerate

   // receive side: MSB arrives first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rx_byte <= '0;
      else if (rx_en) rx_byte <= {rx_byte[BYTE_W-2:0], rx_bit};
   end

   // transmit side: shift left, back-fill with released level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tx_q <= '1;
      else if (tx_load)   tx_q <= tx_val;
      else if (tx_shift)  tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
   end

   assign tx_next_msb = tx_q[BYTE_W-2];

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
   import twi_reg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         NUM_REGS = 12,
   parameter int         OFS_W    = 5,
   parameter logic [7:0] OOR_FILL = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic             reg_we,
   output logic [OFS_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   input  logic [7:0]       reg_rdata
);

   localparam int         BYTE_W   = 8;
   localparam int         BITS_W   = $clog2(BYTE_W + 1);
   localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(BYTE_W);
   localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

   generate
      if (NUM_REGS < 1 || NUM_REGS > (1 << OFS_W)) begin : g_bad_regs
         $error("twi_reg_slave: NUM_REGS must fit in OFS_W offset bits");
      end
      if (NUM_REGS > 255) begin : g_bad_cnt
         $error("twi_reg_slave: NUM_REGS must fit in the length byte");
      end
      if (OFS_W > 5) begin : g_bad_ofs
         $error("twi_reg_slave: the command byte carries at most 5 offset bits");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;

   twi_state_t        state;
   twi_kind_t         kind, ack_kind;
   twi_state_t        ack_to;
   logic [BITS_W-1:0] bitcnt;
   logic [OFS_W-1:0]  ptr;
   logic [7:0]        remain;
   logic              byte_mode;
   logic              cnt_pending;
   logic              bump;
   logic              m_acked;

   logic [7:0] rx_byte;
   logic       tx_next_msb;
   logic       rx_shift, tx_shift, tx_load;
   logic [7:0] tx_val;
   logic       in_range;
   logic       wr_ok;

   twi_line_events u_ev (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   twi_byte_shift #(.BYTE_W(BYTE_W)) u_sh (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_en       (rx_shift),
      .rx_bit      (sda_i),
      .tx_load     (tx_load),
      .tx_val      (tx_val),
      .tx_shift    (tx_shift),
      .rx_byte     (rx_byte),
      .tx_next_msb (tx_next_msb)
   );

   assign in_range = int'(ptr) < NUM_REGS;
   assign wr_ok    = in_range && (byte_mode || remain != 8'd0);

   assign rx_shift = (state == ST_RX) && scl_rise && (bitcnt != LAST_BIT);
   assign tx_shift = (state == ST_TX) && scl_fall && (bitcnt != LAST_BIT);
   assign tx_load  = scl_fall &&
                     (((state == ST_ACK)  && (ack_to == ST_TX)) ||
                      ((state == ST_RACK) && m_acked));
   assign tx_val   = cnt_pending ? CNT_BYTE : (in_range ? reg_rdata : OOR_FILL);

   assign reg_addr  = ptr;
   assign reg_wdata = rx_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         kind        <= K_ADDR;
         ack_kind    <= K_ADDR;
         ack_to      <= ST_WAIT;
         bitcnt      <= '0;
         ptr         <= '0;
         remain      <= '0;
         byte_mode   <= 1'b0;
         cnt_pending <= 1'b0;
         bump        <= 1'b0;
         m_acked     <= 1'b0;
         sda_oe      <= 1'b0;
         reg_we      <= 1'b0;
      end else begin
         reg_we <= 1'b0;
         // pointer bookkeeping for each byte handed to the transmitter
         if (tx_load) begin
            if (cnt_pending)   cnt_pending <= 1'b0;
            else if (in_range) ptr <= ptr + 1'b1;
         end
         if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            bump   <= 1'b0;
         end else if (start_det) begin
            state  <= ST_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            bump   <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise && bitcnt != LAST_BIT) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == LAST_BIT) begin
                     state <= ST_ACK;
                     unique case (kind)
                        K_ADDR: begin
                           if (rx_byte[7:1] == DEV_ADDR) begin
                              sda_oe   <= 1'b1;
                              ack_to   <= rx_byte[0] ? ST_TX : ST_RX;
                              ack_kind <= K_CMD;
                           end else begin
                              ack_to   <= ST_WAIT;
                           end
                        end
                        K_CMD: begin
                           if (rx_byte[6:5] == 2'b00) begin
                              sda_oe      <= 1'b1;
                              ack_to      <= ST_RX;
                              byte_mode   <= rx_byte[7];
                              cnt_pending <= ~rx_byte[7];
                              ptr         <= rx_byte[7] ? rx_byte[OFS_W-1:0] : '0;
                              ack_kind    <= rx_byte[7] ? K_DATA : K_CNT;
                           end else begin
                              ack_to      <= ST_WAIT;
                           end
                        end
                        K_CNT: begin
                           sda_oe   <= 1'b1;
                           ack_to   <= ST_RX;
                           ack_kind <= K_DATA;
                           remain   <= rx_byte;
                        end
                        default: begin
                           if (wr_ok) begin
                              sda_oe   <= 1'b1;
                              reg_we   <= 1'b1;
                              bump     <= 1'b1;
                              ack_to   <= ST_RX;
                              ack_kind <= K_DATA;
                              if (!byte_mode) remain <= remain - 1'b1;
                           end else begin
                              ack_to   <= ST_WAIT;
                           end
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     bump   <= 1'b0;
                     if (bump) ptr <= ptr + 1'b1;
                     unique case (ack_to)
                        ST_TX: begin
                           state  <= ST_TX;
                           sda_oe <= ~tx_val[7];
                        end
                        ST_RX: begin
                           state  <= ST_RX;
                           kind   <= ack_kind;
                           sda_oe <= 1'b0;
                        end
                        default: begin
                           state  <= ST_WAIT;
                           sda_oe <= 1'b0;
                        end
                     endcase
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        sda_oe <= ~tx_next_msb;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     m_acked <= ~sda_i;
                  end else if (scl_fall) begin
                     bitcnt <= '0;
                     if (m_acked) begin
                        state  <= ST_TX;
                        sda_oe <= ~tx_val[7];
                     end else begin
                        state  <= ST_WAIT;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   p_we_in_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (int'(reg_addr) < NUM_REGS));

   p_quiet_after_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> !sda_oe);

   p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && state == ST_IDLE));

   p_start_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_oe && state == ST_RX && kind == K_ADDR));

   p_drive_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

endmodule

// File: tb/twi_reg_slave_test.sv
module twi_reg_slave_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_oe;
   logic       reg_we;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       sda_line;

   logic [7:0] regs [12];
   int         we_cnt = 0;
   int         n_chk = 0;
   int         n_fail = 0;
   int         r11_viol = 0;
   int         r9_viol = 0;
   bit         quiet_win = 1'b0;
   logic       prev_oe = 1'b0;
   logic       prev_scl = 1'b1;

   always #5 clk = ~clk;

   assign sda_line  = m_sda & ~sda_oe;
   assign reg_rdata = (int'(reg_addr) < 12) ? regs[int'(reg_addr) % 12] : 8'h00;

   twi_reg_slave uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   // register-side model
   always_ff @(posedge clk) begin
      if (reg_we) begin
         we_cnt <= we_cnt + 1;
         if (int'(reg_addr) < 12) regs[int'(reg_addr) % 12] <= reg_wdata;
      end
   end

   // line monitor for R11 and R9
   always @(negedge clk) begin
      if (rst_n && sda_oe != prev_oe && m_scl && prev_scl) r11_viol++;
      if (quiet_win && sda_oe) r9_viol++;
      prev_oe  <= sda_oe;
      prev_scl <= m_scl;
   end

   function automatic logic [7:0] pat(input int i, input int seed);
      return 8'((i * 29 + seed * 13 + 7) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(2);
      m_scl = 1'b1; tick(3);
      m_sda = 1'b0; tick(3);
      m_scl = 1'b0; tick(1);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(2);
      m_scl = 1'b1; tick(3);
      m_sda = 1'b1; tick(3);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; tick(3);
         m_scl = 1'b1; tick(4);
         m_scl = 1'b0; tick(1);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      m_sda = 1'b1; tick(3);
      m_scl = 1'b1; tick(2);
      acked = (sda_line == 1'b0);
      tick(2);
      m_scl = 1'b0; tick(1);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit give_ack);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(3);
         m_scl = 1'b1; tick(2);
         b[i] = sda_line;
         tick(2);
         m_scl = 1'b0; tick(1);
      end
      m_sda = give_ack ? 1'b0 : 1'b1; tick(3);
      m_scl = 1'b1; tick(4);
      m_scl = 1'b0; tick(1);
      m_sda = 1'b1;
   endtask

   task automatic byte_write(input int ofs, input logic [7:0] v, output bit a_cmd, output bit a_dat);
      bit a0;
      bus_start();
      send_byte(8'hD2, a0);
      send_byte(8'h80 | 8'(ofs), a_cmd);
      send_byte(v, a_dat);
      bus_stop();
   endtask

   task automatic byte_read(input int ofs, output logic [7:0] v);
      bit a;
      bus_start();
      send_byte(8'hD2, a);
      send_byte(8'h80 | 8'(ofs), a);
      bus_start();
      send_byte(8'hD3, a);
      recv_byte(v, 1'b0);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit a, b2;
      logic [7:0] v;
      int w0;
      for (int i = 0; i < 12; i++) regs[i] = 8'h00;
      tick(4);
      // R12: reset state
      chk(sda_oe == 1'b0, "R12 sda_oe after reset", int'(sda_oe), 0);
      chk(reg_we == 1'b0, "R12 reg_we after reset", int'(reg_we), 0);
      rst_n = 1'b1;
      tick(4);

      // R1: correct address acknowledged
      bus_start(); send_byte(8'hD2, a); bus_stop();
      chk(a, "R1 own write address ack", int'(a), 1);

      // R1: every other address, both directions, is not acknowledged
      w0 = we_cnt;
      for (int ad = 0; ad < 128; ad++) begin
         if (ad == 'h69) continue;
         for (int rw = 0; rw < 2; rw++) begin
            bus_start();
            send_byte(8'((ad << 1) | rw), a);
            send_byte(8'h81, b2);
            bus_stop();
            chk(!a && !b2, "R1 foreign address nack", int'({a, b2}), 0);
         end
      end
      chk(we_cnt == w0, "R1 no write after foreign address", we_cnt - w0, 0);

      // R3/R6: byte write then byte read across the bank
      for (int s = 0; s < 2; s++) begin
         for (int o = 0; o < 12; o++) begin
            w0 = we_cnt;
            byte_write(o, pat(o, s), a, b2);
            chk(a && b2, "R3 byte write acks", int'({a, b2}), 3);
            chk(we_cnt == w0 + 1, "R3 one strobe per byte", we_cnt - w0, 1);
            chk(regs[o] == pat(o, s), "R3 written value", int'(regs[o]), int'(pat(o, s)));
         end
         for (int o = 0; o < 12; o++) begin
            byte_read(o, v);
            chk(v == pat(o, s), "R6 byte read value", int'(v), int'(pat(o, s)));
         end
      end

      // R3: consecutive bytes in one single-byte transfer advance the offset
      bus_start(); send_byte(8'hD2, a); send_byte(8'h84, a);
      send_byte(8'h5A, a); send_byte(8'hA5, b2); bus_stop();
      chk(regs[4] == 8'h5A && regs[5] == 8'hA5, "R3 sequential offsets",
          int'({regs[4], regs[5]}), 'h5AA5);

      // R5/R8: offsets beyond the bank
      for (int o = 12; o < 32; o++) begin
         w0 = we_cnt;
         byte_write(o, 8'h3C, a, b2);
         chk(a && !b2, "R5 out-of-bank write nack", int'({a, b2}), 2);
         chk(we_cnt == w0, "R5 no strobe out of bank", we_cnt - w0, 0);
         byte_read(o, v);
         chk(v == 8'hFF, "R8 out-of-bank read", int'(v), 'hFF);
      end

      // R2: device-select bits non-zero
      foreach (regs[i]) regs[i] = regs[i];
      for (int c = 0; c < 3; c++) begin
         logic [7:0] cmd;
         cmd = (c == 0) ? 8'hA1 : (c == 1) ? 8'hC3 : 8'h20;
         w0 = we_cnt;
         bus_start(); send_byte(8'hD2, a); send_byte(cmd, b2);
         chk(a && !b2, "R2 bad select bits nack", int'({a, b2}), 2);
         send_byte(8'h77, b2); bus_stop();
         chk(!b2 && we_cnt == w0, "R2 no write after bad command", we_cnt - w0, 0);
      end

      // R4: block write with length 3 and 5 data bytes
      for (int o = 0; o < 12; o++) regs[o] = 8'h11;
      w0 = we_cnt;
      bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a);
      chk(a, "R2 block command ack", int'(a), 1);
      send_byte(8'd3, a);
      chk(a, "R4 length byte ack", int'(a), 1);
      for (int k = 0; k < 5; k++) begin
         send_byte(pat(k, 7), a);
         chk(a == (k < 3), "R4 data ack within length", int'(a), int'(k < 3));
      end
      bus_stop();
      chk(we_cnt == w0 + 3, "R4 strobe count", we_cnt - w0, 3);
      for (int o = 0; o < 5; o++) begin
         logic [7:0] e;
         e = (o < 3) ? pat(o, 7) : 8'h11;
         chk(regs[o] == e, "R4 block write contents", int'(regs[o]), int'(e));
      end

      // R7/R8: block read of 14 bytes after the length
      for (int o = 0; o < 12; o++) regs[o] = pat(o, 3);
      bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a);
      bus_start(); send_byte(8'hD3, a);
      recv_byte(v, 1'b1);
      chk(v == 8'h0C, "R7 block read length first", int'(v), 'h0C);
      for (int k = 0; k < 14; k++) begin
         logic [7:0] e;
         e = (k < 12) ? pat(k, 3) : 8'hFF;
         recv_byte(v, k != 13);
         chk(v == e, (k < 12) ? "R7 block read data" : "R8 block read past end",
             int'(v), int'(e));
      end
      // R9: extra clocks after master NACK, slave must stay released
      quiet_win = 1'b1;
      for (int k = 0; k < 9; k++) begin
         tick(3); m_scl = 1'b1; tick(4); m_scl = 1'b0; tick(1);
      end
      quiet_win = 1'b0;
      bus_stop();
      chk(r9_viol == 0, "R9 SDA released after NACK", r9_viol, 0);

      // R10: STOP in the middle of an address byte
      for (int n = 1; n < 8; n++) begin
         bus_start(); send_bits(8'hD2, n); bus_stop();
         chk(sda_oe == 1'b0, "R10 released after mid-byte STOP", int'(sda_oe), 0);
         byte_write(6, pat(n, 9), a, b2);
         chk(a && b2 && regs[6] == pat(n, 9), "R10 transfer after STOP",
             int'(regs[6]), int'(pat(n, 9)));
      end
      // R10: START in the middle of a data byte
      w0 = we_cnt;
      bus_start(); send_byte(8'hD2, a); send_byte(8'h87, a); send_bits(8'hFF, 3);
      bus_start();
      chk(sda_oe == 1'b0 && we_cnt == w0, "R10 released after mid-byte START",
          int'(sda_oe), 0);
      send_byte(8'hD2, a); send_byte(8'h88, a); send_byte(8'h42, b2); bus_stop();
      chk(a && b2 && regs[8] == 8'h42, "R10 address after repeated START",
          int'(regs[8]), 'h42);

      chk(r11_viol == 0, "R11 SDA enable only moves with SCL low", r11_viol, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule